// File: doc/BRIEF.md
# Decimal Arithmetic Adjust Unit

This unit applies the decimal corrections that a legacy 8-bit accumulator needs around binary arithmetic. It takes a low and a high 8-bit register, the incoming carry and auxiliary-carry flags, a 3-bit operation select and an 8-bit immediate base. It returns the corrected registers together with the carry, auxiliary-carry, sign, zero, parity and overflow flags. The binary add, subtract, multiply or divide is done elsewhere. This block only applies the decimal fix-up that follows or precedes it.

Six operations are provided:
- Packed adjust after addition.
- Packed adjust after subtraction.
- Unpacked adjust after addition.
- Unpacked adjust after subtraction.
- A multiply adjust, which splits the low register into a quotient and a remainder by the base.
- A divide adjust, which folds the high register into the low one through the base.

The multiply adjust uses a small iterative restoring divider. All the other operations complete on the clock edge that accepts them.

A caller raises `start` for one cycle with the operands valid. While the unit is `busy`, further `start` pulses are ignored. When the result is ready, `done` pulses high for one cycle. The outputs keep their last values until the next accepted operation.

Top module: `dec_adjust_unit`

## Requirements
- R1: While reset is asserted and after it is released, `done`, `busy`, `fault`, both register outputs and all flag outputs are 0.
- R2: `start` is accepted on a clock edge only while `busy` is 0, and `done` is high for one cycle per accepted operation. For operation codes other than 4 (and for code 4 with a zero base), `done` is high right after the accepting edge. For code 4 with a nonzero base, `busy` is high until the result is ready, and `done` rises on the 9th edge after the accepting edge.
- R3: Code 0 (packed add adjust) works on the low register in two steps.
  - Low step: if the low nibble exceeds 9 or the auxiliary carry is 1, 0x06 is added (modulo 256) and `af_out` is set to 1; otherwise `af_out` is 0.
  - High step: this step then tests the value produced by the low step. If that value exceeds 0x9F or the carry is 1, 0x60 is added and `cf_out` is set to 1; otherwise `cf_out` is 0.
  - The high register passes through unchanged.
- R4: Code 1 (packed subtract adjust) uses the same two tests as R3 in the same order, but subtracts 0x06 and 0x60 (modulo 256) instead of adding them.
- R5: For every operation that does not raise a fault, `sf_out` is bit 7 of the new low register and `zf_out` is 1 when that register is 0. `pf_out` is 1 when the new low register holds an even number of ones. `of_out` is 0 except for code 5.
- R6: Code 2 (unpacked add adjust) tests whether the auxiliary carry is 1 or the low nibble exceeds 9.
  - When the test holds, 6 is added to the low register, the high register is incremented (modulo 256), and both `af_out` and `cf_out` are 1.
  - When the test fails, both flags are 0.
  - In either case, the upper nibble of the low register is cleared.
- R7: Code 3 (unpacked subtract adjust) uses the same test as R6.
  - When the test holds, the high register is decremented, and decremented once more if the low register is below 6. The low register becomes (low − 6) AND 0x0F, and `af_out` and `cf_out` are 1.
  - Otherwise the low register's upper nibble is cleared and both flags are 0.
- R8: Code 4 (multiply adjust) with a nonzero base sets the high register to low ÷ base and the low register to low mod base. `cf_out`, `af_out` and `of_out` are 0.
- R9: Code 4 with a base of 0 sets `fault` to 1, returns both registers unchanged and clears all six flags. Every other operation leaves `fault` at 0.
- R10: Code 5 (divide adjust) forms high × base + low as a 16-bit sum. It writes the sum's low byte to the low register and clears the high register.
- R11: For code 5, `cf_out` is 1 when the sum exceeds 0xFF, and `af_out` is 1 when bit 3 of the product high × base differs from bit 3 of the sum. `of_out` is 1 when bit 7 of the new low register differs from bit 7 of the incoming low register.
- R12: A `start` raised while `busy` is 1 has no effect: it does not change the operation in flight and produces no extra `done`. Between `done` pulses, the outputs keep their values.
- R13: Codes 6 and 7 return both registers unchanged with all six flags and `fault` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Request an operation; sampled while idle |
| op_sel | input | 3 | Operation code: 0 packed add, 1 packed sub, 2 unpacked add, 3 unpacked sub, 4 multiply adjust, 5 divide adjust, 6/7 pass |
| lo_in | input | 8 | Low register value |
| hi_in | input | 8 | High register value |
| af_in | input | 1 | Incoming auxiliary carry |
| cf_in | input | 1 | Incoming carry |
| base_in | input | 8 | Immediate base for codes 4 and 5 |
| busy | output | 1 | Multiply adjust in progress |
| done | output | 1 | One-cycle result strobe |
| lo_out | output | 8 | Updated low register |
| hi_out | output | 8 | Updated high register |
| cf_out | output | 1 | Carry flag |
| af_out | output | 1 | Auxiliary-carry flag |
| sf_out | output | 1 | Sign flag |
| zf_out | output | 1 | Zero flag |
| pf_out | output | 1 | Parity flag (even count of ones) |
| of_out | output | 1 | Overflow flag |
| fault | output | 1 | Zero base in multiply adjust |

## Verification
The bench drives cases where the two packed steps interact. One example is 0x9A with both flags clear: the low step gives 0xA0, and only a design that runs the high test on that corrected value ends at 0x00 with carry set. A design that ran the two tests in parallel would return 0xA0 with carry clear. The unpacked subtract is driven with a low value below 6, where a missing second borrow leaves the high register one too large. It is also driven with a high register that wraps when incremented.

The multiply adjust is exercised with a zero base, which a careless design would divide by or hang on, and with bases larger than the low value. The divide adjust is exercised with sums above 0xFF and with auxiliary-carry boundary values. A `start` is also pulsed into a running multiply adjust, which a design without the busy guard would corrupt or answer twice.

// File: rtl/dau_pkg.sv
// Shared definitions for the decimal adjust unit.
// Assumes an 8-bit register pair made of two 4-bit decimal digits.
package dau_pkg;
    localparam int DW = 8;              // register width
    localparam int NW = DW / 2;         // decimal digit width
    localparam int W2 = 2 * DW;         // product / sum width

    localparam logic [DW-1:0] NIB_MASK   = DW'((1 << NW) - 1);
    localparam logic [DW-1:0] LOW_STEP   = DW'(6);
    localparam logic [DW-1:0] HIGH_STEP  = DW'(6 << NW);
    localparam logic [DW-1:0] HIGH_LIMIT = DW'((10 << NW) - 1);
    localparam logic [NW-1:0] DIGIT_MAX  = NW'(9);

    typedef enum logic [2:0] {
        OP_PK_ADD = 3'd0,
        OP_PK_SUB = 3'd1,
        OP_UN_ADD = 3'd2,
        OP_UN_SUB = 3'd3,
        OP_MUL_AJ = 3'd4,
        OP_DIV_AJ = 3'd5,
        OP_PASS6  = 3'd6,
        OP_PASS7  = 3'd7
    } dau_op_e;

    typedef struct packed {
        logic [DW-1:0] lo;
        logic [DW-1:0] hi;
        logic          cf;
        logic          af;
        logic          sf;
        logic          zf;
        logic          pf;
        logic          of;
        logic          fault;
    } dau_res_t;

    // Even parity over a register value: 1 when the count of ones is even.
    function automatic logic even_ones(input logic [DW-1:0] v);
        return ~(^v);
    endfunction
endpackage

// File: rtl/dau_bcd_fix.sv
// Combinational packed and unpacked decimal correction (op codes 0..3).
// Assumes the caller selects this result only for those codes; for
// other codes it returns the registers unchanged with flags clear.
module dau_bcd_fix
    import dau_pkg::*;
(
    input  dau_op_e       op,
    input  logic [DW-1:0] lo,
    input  logic [DW-1:0] hi,
    input  logic          af_i,
    input  logic          cf_i,
    output dau_res_t      res
);
    logic          digit_big;
    logic          low_fix;
    logic          is_sub;
    logic [DW-1:0] step1;
    logic          high_fix;
    logic [DW-1:0] step2;
    logic [DW-1:0] un_lo;
    logic [DW-1:0] un_hi;
    logic [DW-1:0] borrow2;

    // Low-digit test shared by all four corrections.
    always_comb begin
        digit_big = lo[NW-1:0] > DIGIT_MAX;
        low_fix   = digit_big | af_i;
        is_sub    = (op == OP_PK_SUB);
    end

    // Packed path: the high test looks at the low-corrected value.
    always_comb begin
        if (low_fix) step1 = is_sub ? (lo - LOW_STEP) : (lo + LOW_STEP);
        else         step1 = lo;
        high_fix = (step1 > HIGH_LIMIT) | cf_i;
        if (high_fix) step2 = is_sub ? (step1 - HIGH_STEP) : (step1 + HIGH_STEP);
        else          step2 = step1;
    end

    // Unpacked path: digit in the low nibble, carry or borrow into high.
    always_comb begin
        borrow2 = (lo < LOW_STEP) ? DW'(2) : DW'(1);
        if (!low_fix) begin
            un_lo = lo & NIB_MASK;
            un_hi = hi;
        end else if (op == OP_UN_SUB) begin
            un_lo = (lo - LOW_STEP) & NIB_MASK;
            un_hi = hi - borrow2;
        end else begin
            un_lo = (lo + LOW_STEP) & NIB_MASK;
            un_hi = hi + DW'(1);
        end
    end

    // Result assembly with flags taken from the new low register.
    always_comb begin
        res = '0;
        unique case (op)
            OP_PK_ADD, OP_PK_SUB: begin
                res.lo = step2;
                res.hi = hi;
                res.af = low_fix;
                res.cf = high_fix;
            end
            OP_UN_ADD, OP_UN_SUB: begin
                res.lo = un_lo;
                res.hi = un_hi;
                res.af = low_fix;
                res.cf = low_fix;
            end
            default: begin
                res.lo = lo;
                res.hi = hi;
            end
        endcase
        if (op inside {OP_PK_ADD, OP_PK_SUB, OP_UN_ADD, OP_UN_SUB}) begin
            res.sf = res.lo[DW-1];
            res.zf = (res.lo == '0);
            res.pf = even_ones(res.lo);
        end
    end
endmodule

// File: rtl/dau_fold.sv
// Combinational divide-adjust fold: low := low byte of (high*base + low),
// high := 0. Assumes the 16-bit sum cannot overflow (255*255+255 fits).
module dau_fold
    import dau_pkg::*;
(
    input  logic [DW-1:0] lo,
    input  logic [DW-1:0] hi,
    input  logic [DW-1:0] base,
    output dau_res_t      res
);
    logic [W2-1:0] prod;
    logic [W2-1:0] sum;

    // Product and widened sum.
    always_comb begin
        prod = W2'(hi) * W2'(base);
        sum  = prod + W2'(lo);
    end

    // Result and flags.
    always_comb begin
        res       = '0;
        res.lo    = sum[DW-1:0];
        res.hi    = '0;
        res.cf    = (sum[W2-1:DW] != '0);
        res.af    = prod[3] ^ sum[3];
        res.of    = sum[DW-1] ^ lo[DW-1];
        res.sf    = sum[DW-1];
        res.zf    = (sum[DW-1:0] == '0);
        res.pf    = even_ones(sum[DW-1:0]);
    end
endmodule

// File: rtl/dau_divider.sv
// Iterative restoring divider, one quotient bit per cycle.
// go loads operands (divisor must be nonzero); after DW step cycles
// valid is high for one cycle with quo and rem, then the unit idles.
module dau_divider #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          go,
    input  logic [DW-1:0] dividend,
    input  logic [DW-1:0] divisor,
    output logic          valid,
    output logic [DW-1:0] quo,
    output logic [DW-1:0] rem
);
    localparam int CW  = $clog2(DW + 1);
    localparam int DW2 = 2 * DW;

    logic          run;
    logic [CW-1:0] cnt;
    logic [DW-1:0] dvs;
    logic [DW-1:0] dvd;
    logic [DW:0]   partial;
    logic          fits;

    // Trial subtraction for the current step.
    always_comb begin
        partial = {rem, quo[DW-1]};
        fits    = partial >= {1'b0, dvs};
    end

    assign valid = run && (cnt == '0);

    // Load, shift-subtract steps, and release.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run <= 1'b0;
            cnt <= '0;
            dvs <= '0;
            dvd <= '0;
            quo <= '0;
            rem <= '0;
        end else if (go) begin
            run <= 1'b1;
            cnt <= CW'(DW);
            dvs <= divisor;
            dvd <= dividend;
            quo <= dividend;
            rem <= '0;
        end else if (run) begin
            if (cnt != '0) begin
                cnt <= cnt - CW'(1);
                if (fits) begin
                    rem <= DW'(partial - {1'b0, dvs});
                    quo <= {quo[DW-2:0], 1'b1};
                end else begin
                    rem <= partial[DW-1:0];
                    quo <= {quo[DW-2:0], 1'b0};
                end
            end else begin
                run <= 1'b0;
            end
        end
    end

    // R8: a finished division reconstructs the dividend exactly.
    assert_div_exact_R8: assert property (@(posedge clk) disable iff (!rst_n)
        valid |-> ((DW2'(quo) * DW2'(dvs) + DW2'(rem)) == DW2'(dvd)));

    // R8: the remainder is always below the divisor when finished.
    assert_rem_small_R8: assert property (@(posedge clk) disable iff (!rst_n)
        valid |-> (rem < dvs));
endmodule

// File: rtl/dec_adjust_unit.sv
// Decimal arithmetic adjust unit, top level.
// Accepts one operation per start while idle; combinational corrections
// finish on the accepting edge, multiply adjust runs the iterative divider.
// Outputs are registered and hold between done pulses.
module dec_adjust_unit
    import dau_pkg::*;
(
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [2:0]   op_sel,
    input  logic [7:0]   lo_in,
    input  logic [7:0]   hi_in,
    input  logic         af_in,
    input  logic         cf_in,
    input  logic [7:0]   base_in,
    output logic         busy,
    output logic         done,
    output logic [7:0]   lo_out,
    output logic [7:0]   hi_out,
    output logic         cf_out,
    output logic         af_out,
    output logic         sf_out,
    output logic         zf_out,
    output logic         pf_out,
    output logic         of_out,
    output logic         fault
);
    typedef enum logic {ST_IDLE, ST_WAIT} st_e;

    st_e      state;
    dau_op_e  op;
    dau_op_e  op_q;
    dau_res_t bcd_res;
    dau_res_t fold_res;
    dau_res_t fast_res;
    dau_res_t div_res;
    dau_res_t out_q;
    logic     accept;
    logic     div_go;
    logic     div_valid;
    logic [DW-1:0] div_quo;
    logic [DW-1:0] div_rem;

    assign op = dau_op_e'(op_sel);

    dau_bcd_fix u_bcd (
        .op   (op),
        .lo   (lo_in),
        .hi   (hi_in),
        .af_i (af_in),
        .cf_i (cf_in),
        .res  (bcd_res)
    );

    dau_fold u_fold (
        .lo   (lo_in),
        .hi   (hi_in),
        .base (base_in),
        .res  (fold_res)
    );

    dau_divider #(.DW(DW)) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .go       (div_go),
        .dividend (lo_in),
        .divisor  (base_in),
        .valid    (div_valid),
        .quo      (div_quo),
        .rem      (div_rem)
    );

    // Handshake decode: accept only while idle, divider only for a real base.
    always_comb begin
        accept = start && (state == ST_IDLE);
        div_go = accept && (op == OP_MUL_AJ) && (base_in != '0);
    end

    // Single-edge result select for every case that needs no divider.
    always_comb begin
        fast_res = '0;
        unique case (op)
            OP_PK_ADD, OP_PK_SUB, OP_UN_ADD, OP_UN_SUB: fast_res = bcd_res;
            OP_DIV_AJ: fast_res = fold_res;
            OP_MUL_AJ: begin
                fast_res.lo    = lo_in;
                fast_res.hi    = hi_in;
                fast_res.fault = 1'b1;
            end
            default: begin
                fast_res.lo = lo_in;
                fast_res.hi = hi_in;
            end
        endcase
    end

    // Multiply-adjust result built from the divider outputs.
    always_comb begin
        div_res    = '0;
        div_res.hi = div_quo;
        div_res.lo = div_rem;
        div_res.sf = div_rem[DW-1];
        div_res.zf = (div_rem == '0);
        div_res.pf = even_ones(div_rem);
    end

    // Control state, result register and done strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            op_q  <= OP_PK_ADD;
            out_q <= '0;
            done  <= 1'b0;
        end else begin
            done <= 1'b0;
            if (accept) begin
                op_q <= op;
                if (div_go) begin
                    state <= ST_WAIT;
                end else begin
                    out_q <= fast_res;
                    done  <= 1'b1;
                end
            end else if (state == ST_WAIT && div_valid) begin
                out_q <= div_res;
                done  <= 1'b1;
                state <= ST_IDLE;
            end
        end
    end

    assign busy   = (state == ST_WAIT);
    assign lo_out = out_q.lo;
    assign hi_out = out_q.hi;
    assign cf_out = out_q.cf;
    assign af_out = out_q.af;
    assign sf_out = out_q.sf;
    assign zf_out = out_q.zf;
    assign pf_out = out_q.pf;
    assign of_out = out_q.of;
    assign fault  = out_q.fault;

    // R2: no result strobe while the divider is still running.
    assert_no_done_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !done);

    // R2: a divided multiply-adjust result follows a busy period.
    assert_mul_after_wait_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (done && op_q == OP_MUL_AJ && !fault) |-> $past(busy));

    // R9: a fault returns the registers presented on the accepting edge.
    assert_fault_keeps_regs_R9: assert property (@(posedge clk) disable iff (!rst_n)
        fault && done |-> (lo_out == $past(lo_in) && hi_out == $past(hi_in)));

    // R6: unpacked adjustments always leave a single digit in the low register.
    assert_unpacked_digit_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (done && (op_q == OP_UN_ADD || op_q == OP_UN_SUB)) |-> (lo_out[7:4] == 4'h0));

    // R10: divide adjust always clears the high register.
    assert_fold_hi_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (done && op_q == OP_DIV_AJ) |-> (hi_out == 8'h00));

    // R12: outputs only move together with a done strobe.
    assert_hold_between_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> ($stable(lo_out) && $stable(hi_out) && $stable(fault)));
endmodule

// File: tb/sim_dec_adjust_unit.sv
`timescale 1ns/1ps
module sim_dec_adjust_unit;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic [2:0] op_sel = 3'd0;
    logic [7:0] lo_in = 8'h00;
    logic [7:0] hi_in = 8'h00;
    logic       af_in = 1'b0;
    logic       cf_in = 1'b0;
    logic [7:0] base_in = 8'h00;
    logic       busy, done, cf_out, af_out, sf_out, zf_out, pf_out, of_out, fault;
    logic [7:0] lo_out, hi_out;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;   // 250 MHz

    dec_adjust_unit u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .op_sel(op_sel),
        .lo_in(lo_in), .hi_in(hi_in), .af_in(af_in), .cf_in(cf_in),
        .base_in(base_in), .busy(busy), .done(done), .lo_out(lo_out),
        .hi_out(hi_out), .cf_out(cf_out), .af_out(af_out), .sf_out(sf_out),
        .zf_out(zf_out), .pf_out(pf_out), .of_out(of_out), .fault(fault)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic bit even_par(input int v);
        int n = 0;
        for (int i = 0; i < 8; i++) n += (v >> i) & 1;
        return (n % 2) == 0;
    endfunction

    // Expected registers {hi,lo} and flags {cf,af,sf,zf,pf,of,fault} from the requirements.
    task automatic model(input int op, input int lo, input int hi, input bit af, input bit cf,
                         input int base, output logic [15:0] regs, output logic [6:0] flg);
        int elo, ehi, p, s;
        bit c, a, o, f;
        c = 0; a = 0; o = 0; f = 0; elo = lo; ehi = hi;
        case (op)
            0, 1: begin
                if ((lo % 16) > 9 || af) begin elo = (op == 0) ? elo + 6 : elo - 6; elo &= 255; a = 1; end
                if (elo > 159 || cf) begin elo = (op == 0) ? elo + 96 : elo - 96; elo &= 255; c = 1; end
            end
            2: begin
                if ((lo % 16) > 9 || af) begin elo = (lo + 6) % 16; ehi = (hi + 1) & 255; a = 1; c = 1; end
                else elo = lo % 16;
            end
            3: begin
                if ((lo % 16) > 9 || af) begin
                    ehi = (hi - 1 - ((lo < 6) ? 1 : 0)) & 255; elo = (lo - 6) & 15; a = 1; c = 1;
                end else elo = lo % 16;
            end
            4: begin
                if (base == 0) f = 1;
                else begin ehi = lo / base; elo = lo % base; end
            end
            5: begin
                p = hi * base; s = p + lo; elo = s & 255; ehi = 0;
                c = s > 255; a = ((p >> 3) & 1) != ((s >> 3) & 1);
                o = ((elo >> 7) & 1) != ((lo >> 7) & 1);
            end
            default: ;
        endcase
        regs = {8'(ehi), 8'(elo)};
        if (f || op > 5) flg = {6'b0, f};
        else flg = {c, a, 1'(elo >> 7), elo == 0, even_par(elo), o, 1'b0};
    endtask

    // Drive one operation and return the edge count until done (1 = accepting edge).
    task automatic issue(input int op, input int lo, input int hi, input bit af, input bit cf,
                         input int base, output int n);
        @(negedge clk);
        op_sel = 3'(op); lo_in = 8'(lo); hi_in = 8'(hi); af_in = af; cf_in = cf;
        base_in = 8'(base); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        n = 1;
        while (!done && n < 40) begin @(negedge clk); n++; end
    endtask

    task automatic run_case(input string req, input int op, input int lo, input int hi,
                            input bit af, input bit cf, input int base, input int exp_n);
        int n;
        logic [15:0] er;
        logic [6:0]  ef;
        model(op, lo, hi, af, cf, base, er, ef);
        issue(op, lo, hi, af, cf, base, n);
        check({req, " regs"}, {16'h0, hi_out, lo_out}, {16'h0, er});
        check({req, " flags"}, {25'h0, cf_out, af_out, sf_out, zf_out, pf_out, of_out, fault},
              {25'h0, ef});
        check({req, " latency R2"}, n, exp_n);
    endtask

    task automatic t_reset;
        check("R1 reset outputs", {busy, done, fault, lo_out, hi_out, cf_out, af_out, sf_out,
              zf_out, pf_out, of_out}, 0);
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        check("R1 after release", {busy, done, lo_out, hi_out}, 0);
    endtask

    task automatic t_packed_add;
        run_case("R3 0x9A chained", 0, 8'h9A, 8'h11, 0, 0, 0, 1);
        check("R3 0x9A -> 00 cf", {lo_out, cf_out, af_out, zf_out}, {8'h00, 3'b111});
        run_case("R3 0x99 no fix", 0, 8'h99, 0, 0, 0, 0, 1);
        run_case("R3 0x15 af", 0, 8'h15, 0, 1, 0, 0, 1);
        run_case("R3 0x3C cf", 0, 8'h3C, 0, 0, 1, 0, 1);
        run_case("R5 0xFF wrap", 0, 8'hFF, 0, 0, 0, 0, 1);
    endtask

    task automatic t_packed_sub;
        run_case("R4 0x0F", 1, 8'h0F, 0, 0, 0, 0, 1);
        run_case("R4 0x00 af", 1, 8'h00, 0, 1, 0, 0, 1);
        check("R4 0x00 af -> 9A", {lo_out, cf_out, pf_out, sf_out}, {8'h9A, 3'b111});
        run_case("R4 0xA0 high only", 1, 8'hA0, 0, 0, 0, 0, 1);
    endtask

    task automatic t_unpacked;
        run_case("R6 0x0B hi wrap", 2, 8'h0B, 8'hFF, 0, 0, 0, 1);
        run_case("R6 0x35 clear", 2, 8'h35, 8'h04, 0, 0, 0, 1);
        run_case("R6 af set", 2, 8'h02, 8'h07, 1, 0, 0, 1);
        run_case("R7 low below 6", 3, 8'h02, 8'h05, 1, 0, 0, 1);
        check("R7 double borrow", {hi_out, lo_out}, {8'h03, 8'h0C});
        run_case("R7 low nibble big", 3, 8'h1E, 8'h05, 0, 0, 0, 1);
        run_case("R7 no fix", 3, 8'h47, 8'h05, 0, 0, 0, 1);
    endtask

    task automatic t_mul_adjust;
        run_case("R8 200/10", 4, 200, 0, 0, 0, 10, 10);
        check("R8 200/10 value", {hi_out, lo_out}, {8'd20, 8'd0});
        run_case("R8 base > lo", 4, 7, 3, 0, 0, 250, 10);
        run_case("R8 base 1", 4, 255, 0, 0, 0, 1, 10);
        run_case("R8 base 255", 4, 254, 9, 0, 0, 255, 10);
    endtask

    task automatic t_zero_base;
        run_case("R9 zero base", 4, 8'h37, 8'h42, 1, 1, 0, 1);
        check("R9 fault", {fault, busy}, 2'b10);
    endtask

    task automatic t_fold;
        run_case("R10 small", 5, 5, 3, 0, 0, 10, 1);
        run_case("R11 carry", 5, 200, 9, 0, 0, 10, 1);
        run_case("R11 aux", 5, 8, 1, 0, 0, 10, 1);
        run_case("R11 overflow", 5, 8'h10, 1, 0, 0, 8'h70, 1);
    endtask

    task automatic t_busy_ignore;
        int n;
        int dones;
        @(negedge clk);
        op_sel = 3'd4; lo_in = 8'd200; hi_in = 8'd0; base_in = 8'd7; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check("R12 busy raised", busy, 1);
        repeat (2) @(negedge clk);
        op_sel = 3'd0; lo_in = 8'h9A; base_in = 8'd3; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        n = 0; dones = 0;
        while (!done && n < 40) begin @(negedge clk); n++; end
        check("R12 first result kept", {hi_out, lo_out}, {8'd28, 8'd4});
        for (int i = 0; i < 12; i++) begin
            @(negedge clk);
            if (done) dones++;
        end
        check("R12 no extra done", dones, 0);
        check("R12 outputs hold", {hi_out, lo_out}, {8'd28, 8'd4});
    endtask

    task automatic t_pulse_width;
        int n;
        issue(0, 8'h12, 0, 0, 0, 0, n);
        @(negedge clk);
        check("R2 done one cycle", done, 0);
    endtask

    task automatic t_reserved;
        run_case("R13 code 6", 6, 8'h9A, 8'h33, 1, 1, 5, 1);
        run_case("R13 code 7", 7, 8'h00, 8'hFE, 1, 1, 0, 1);
    endtask

    initial begin
        #(4 * 150000);
        errors++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset;
        t_packed_add;
        t_packed_sub;
        t_unpacked;
        t_mul_adjust;
        t_zero_base;
        t_fold;
        t_busy_ignore;
        t_pulse_width;
        t_reserved;
        repeat (2) @(negedge clk);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule